// File: doc/BRIEF.md
# Event-synchronised digital I/O port

This block is a process-data digital I/O port. An 8-bit configuration register controls it. A set of input pins is copied into an input data register when a chosen capture event occurs. The capture event can be a start-of-frame pulse, a rising edge on an asynchronous latch pin, or one of two sync pulses.

A staged output word is transferred to the output pins when a chosen update event occurs. The update event can be an end-of-frame pulse, one of the sync pulses, or a watchdog trigger pulse. A strobe output marks each output update, and its polarity is programmable. When the process-data watchdog expires, the outputs are cleared. The clear happens either at once or at the next output event.

Frame decoding, sync generation, the watchdog timer and loading of the configuration all live outside this block. Each of them reaches the block as a single-cycle pulse or as a write to the configuration register. Configuration bit map, MSB first: [7:6] update select, [5:4] capture select, [3] deferred clear, [2] all-bidirectional, [1] watchdog-strobe mode, [0] strobe active-low.

Top module: `pdio_port`

## Requirements
- R1: After reset the configuration register holds 0x00, `pins_out` and `in_data` are 0, `outvalid` is low and `pins_oe` equals `dir_cfg`. A write on `cfg_we` loads `cfg_wdata` at the next clock edge.
- R2: Capture select bits [5:4] choose the event that loads `in_data` from `pins_in` at the clock edge that ends that event's cycle. The codes are 00 for `sof_pulse`, 01 for a `latch_in` rising edge, 10 for `sync0_pulse` and 11 for `sync1_pulse`. No other event changes `in_data`.
- R3: `latch_in` passes through a two-flop synchroniser and then a rising-edge detector. A rise that is set up before clock edge k is captured at edge k+2. One rise gives exactly one capture.
- R4: When bit 1 is 0, update select bits [7:6] choose the event that loads `pins_out` from `out_stage`. The codes are 00 for `eof_pulse`, 10 for `sync0_pulse` and 11 for `sync1_pulse`.
- R5: When bit 1 is 0 and bits [7:6] are 01, no event ever loads `pins_out`.
- R6: When bit 1 is 1, `wd_trig_pulse` alone loads `pins_out`, whatever the value of bits [7:6].
- R7: `outvalid` is active for exactly one clock after each output event. That clock is the first one in which `pins_out` shows the new value. Bit 0 set to 0 makes the active level high; bit 0 set to 1 makes it low.
- R8: When bit 3 is 0, `wd_expire_pulse` clears `pins_out` at the clock edge that ends its cycle. This clear takes priority over a load in the same cycle.
- R9: When bit 3 is 1, `wd_expire_pulse` leaves `pins_out` unchanged. The first output event that follows clears `pins_out` instead of loading it. Later events load again.
- R10: When bit 2 is 0, `pins_oe` equals `dir_cfg`, and only pins whose `dir_cfg` bit is 0 (1 means output) are captured; the other bits of `in_data` read 0. When bit 2 is 1, `pins_oe` is all ones and every pin is captured.
- R11: `latch_sof_stat` follows `sof_pulse` in the same cycle when capture select is 00, 10 or 11. When capture select is 01, it shows the synchronised `latch_in` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| sof_pulse | input | 1 | Start-of-frame event pulse |
| eof_pulse | input | 1 | End-of-frame event pulse |
| sync0_pulse | input | 1 | First sync event pulse |
| sync1_pulse | input | 1 | Second sync event pulse |
| wd_trig_pulse | input | 1 | Watchdog trigger pulse |
| wd_expire_pulse | input | 1 | Watchdog expiry pulse |
| latch_in | input | 1 | Asynchronous latch pin |
| dir_cfg | input | W | Per-pin direction, 1 = output |
| pins_in | input | W | Input pin levels |
| out_stage | input | W | Staged output data |
| pins_out | output | W | Output data register |
| pins_oe | output | W | Per-pin output enable |
| in_data | output | W | Input data register |
| outvalid | output | 1 | Output event strobe, polarity programmable |
| latch_sof_stat | output | 1 | Start-of-frame / latch status |

## Verification
The bench builds the port with W = 4. At that width all sixteen direction patterns can be swept in both pin modes, and every capture code can be crossed with every event source. Every update code is crossed with both strobe modes, both polarities and all four update-event sources. This covers the ignored update field in trigger mode, the reserved code and the polarity inversion. Separate sequences cover immediate and deferred watchdog clearing, the latch synchroniser latency and the status output.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  typedef struct packed {
    logic [1:0] upd_sel;
    logic [1:0] cap_sel;
    logic       wd_defer;
    logic       bidir;
    logic       ov_wdmode;
    logic       ov_low;
  } cfg_t;

  localparam logic [1:0] CAP_LATCH = 2'b01;

  // Event vector is ordered so that index equals the select code.
  function automatic logic pick_event(input logic [1:0] sel, input logic [3:0] evts);
    return evts[sel];
  endfunction

  // Capture mask: all pins in bidirectional mode, else input-direction pins only.
  function automatic logic [31:0] cap_mask(input logic bidir, input logic [31:0] dir);
    return bidir ? '1 : ~dir;
  endfunction
endpackage

// File: rtl/pdio_latch_sync.sv
module pdio_latch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pdio_event_sel.sv
module pdio_event_sel
  import pdio_pkg::*;
(
  input  cfg_t cfg,
  input  logic sof,
  input  logic eof,
  input  logic sync0,
  input  logic sync1,
  input  logic latch_rise,
  input  logic wd_trig,
  output logic cap_evt,
  output logic upd_evt
);
  logic upd_by_sel;

  assign cap_evt    = pick_event(cfg.cap_sel, {sync1, sync0, latch_rise, sof});
  assign upd_by_sel = pick_event(cfg.upd_sel, {sync1, sync0, 1'b0, eof});
  assign upd_evt    = cfg.ov_wdmode ? wd_trig : upd_by_sel;
endmodule

// File: rtl/pdio_out_reg.sv
module pdio_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_evt,
  input  logic         wd_expire,
  input  logic         defer,
  input  logic [W-1:0] stage,
  output logic [W-1:0] q,
  output logic         ev_q,
  output logic         pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      pend <= 1'b0;
      ev_q <= 1'b0;
    end else begin
      ev_q <= upd_evt;
      if (wd_expire && !defer) begin
        q    <= '0;
        pend <= 1'b0;
      end else begin
        if (upd_evt) begin
          q    <= pend ? '0 : stage;
          pend <= 1'b0;
        end
        if (wd_expire) pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdio_port.sv
module pdio_port
  import pdio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_wdata,
  input  logic         sof_pulse,
  input  logic         eof_pulse,
  input  logic         sync0_pulse,
  input  logic         sync1_pulse,
  input  logic         wd_trig_pulse,
  input  logic         wd_expire_pulse,
  input  logic         latch_in,
  input  logic [W-1:0] dir_cfg,
  input  logic [W-1:0] pins_in,
  input  logic [W-1:0] out_stage,
  output logic [W-1:0] pins_out,
  output logic [W-1:0] pins_oe,
  output logic [W-1:0] in_data,
  output logic         outvalid,
  output logic         latch_sof_stat
);
  cfg_t         cfg_q;
  logic         latch_lvl, latch_rise;
  logic         cap_evt, upd_evt;
  logic         ev_q, pend;
  logic [31:0]  mask32;
  logic [W-1:0] cap_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  pdio_latch_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(latch_in),
    .level(latch_lvl), .rise(latch_rise)
  );

  pdio_event_sel u_sel (
    .cfg(cfg_q), .sof(sof_pulse), .eof(eof_pulse), .sync0(sync0_pulse),
    .sync1(sync1_pulse), .latch_rise(latch_rise), .wd_trig(wd_trig_pulse),
    .cap_evt(cap_evt), .upd_evt(upd_evt)
  );

  pdio_out_reg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .wd_expire(wd_expire_pulse),
    .defer(cfg_q.wd_defer), .stage(out_stage), .q(pins_out), .ev_q(ev_q), .pend(pend)
  );

  assign mask32 = cap_mask(cfg_q.bidir, 32'(dir_cfg));
  assign cap_m  = mask32[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_data <= '0;
    else if (cap_evt) in_data <= pins_in & cap_m;
  end

  assign pins_oe        = cfg_q.bidir ? '1 : dir_cfg;
  assign outvalid       = ev_q ^ cfg_q.ov_low;
  assign latch_sof_stat = (cfg_q.cap_sel == CAP_LATCH) ? latch_lvl : sof_pulse;
endmodule

// File: rtl/pdio_port_chk.sv
module pdio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   cfg,
  input logic         cap_evt,
  input logic         upd_evt,
  input logic         latch_rise,
  input logic         wd_expire_pulse,
  input logic [W-1:0] pins_out,
  input logic [W-1:0] pins_oe,
  input logic [W-1:0] in_data,
  input logic         outvalid
);
  // R2
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(in_data));
  // R3
  latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise |=> !latch_rise);
  // R5
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7:6] == 2'b01 && !cfg[1] && !wd_expire_pulse) |=> $stable(pins_out));
  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (outvalid != cfg[0]));
  // R7
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> (outvalid == cfg[0]));
  // R8
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire_pulse && !cfg[3]) |=> (pins_out == '0));
  // R10
  bidir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[2] |-> (pins_oe == '1));
endmodule

bind pdio_port pdio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .cap_evt(cap_evt), .upd_evt(upd_evt),
  .latch_rise(latch_rise), .wd_expire_pulse(wd_expire_pulse),
  .pins_out(pins_out), .pins_oe(pins_oe), .in_data(in_data), .outvalid(outvalid)
);

// File: tb/pdio_port_tb.sv
module pdio_port_tb;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, sof = 0, eof = 0, s0 = 0, s1 = 0, wdt = 0, wde = 0, latch = 0;
  logic [7:0] cfg_wdata = '0;
  logic [W-1:0] dir_cfg = 4'b1010, pins_in = '0, out_stage = '0;
  logic [W-1:0] pins_out, pins_oe, in_data;
  logic outvalid, stat;
  int nvec = 0, nerr = 0;

  always #5 clk = ~clk;

  pdio_port #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sof_pulse(sof), .eof_pulse(eof), .sync0_pulse(s0), .sync1_pulse(s1),
    .wd_trig_pulse(wdt), .wd_expire_pulse(wde), .latch_in(latch),
    .dir_cfg(dir_cfg), .pins_in(pins_in), .out_stage(out_stage),
    .pins_out(pins_out), .pins_oe(pins_oe), .in_data(in_data),
    .outvalid(outvalid), .latch_sof_stat(stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // 0 sof, 1 eof, 2 sync0, 3 sync1, 4 wd trig, 5 wd expire; check follows at next negedge
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: sof = 1; 1: eof = 1; 2: s0 = 1; 3: s1 = 1; 4: wdt = 1; default: wde = 1;
    endcase
    @(negedge clk);
    {sof, eof, s0, s1, wdt, wde} = '0;
  endtask

  // Capture source e: 0 sof, 1 latch rise, 2 sync0, 3 sync1
  task automatic cap_event(input int e);
    if (e == 1) begin
      @(negedge clk); latch = 1;
      repeat (3) @(negedge clk);
    end else pulse(e == 0 ? 0 : e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pins_out", pins_out, 0);
    chk("R1 in_data", in_data, 0);
    chk("R1 outvalid", outvalid, 0);
    chk("R1 oe", pins_oe, 4'b1010);
    rst_n = 1;
    dir_cfg = '0;

    // R2 capture select sweep, R3 latch latency
    for (int sel = 0; sel < 4; sel++) begin
      wr_cfg(8'(sel << 4));
      for (int e = 0; e < 4; e++) begin
        logic [W-1:0] prev;
        prev = in_data;
        pins_in = W'(sel * 4 + e + 1);
        if (e == 1) begin
          @(negedge clk); latch = 1;
          @(negedge clk); @(negedge clk);
          chk("R3 not yet", in_data, prev);
          @(negedge clk);
        end else cap_event(e);
        chk("R2 capture", in_data, (sel == e) ? pins_in : prev);
        if (e == 1) begin
          repeat (5) @(negedge clk);
          chk("R3 single", in_data, (sel == e) ? pins_in : prev);
          latch = 0; repeat (4) @(negedge clk);
        end
      end
    end

    // R4 R5 R6 R7 update sweep
    for (int mode = 0; mode < 2; mode++)
      for (int pol = 0; pol < 2; pol++)
        for (int us = 0; us < 4; us++) begin
          wr_cfg(8'((us << 6) | (mode << 1) | pol));
          for (int e = 1; e < 5; e++) begin
            logic [W-1:0] prev;
            logic hit;
            prev = pins_out;
            out_stage = W'(e * 3 + us + mode * 5 + pol);
            if (mode == 1) hit = (e == 4);
            else hit = (us == 0 && e == 1) || (us == 2 && e == 2) || (us == 3 && e == 3);
            pulse(e);
            chk(mode ? "R6 update" : (us == 1 ? "R5 reserved" : "R4 update"),
                pins_out, hit ? out_stage : prev);
            chk("R7 strobe", outvalid, hit ? 1 - pol : pol);
            @(negedge clk);
            chk("R7 one clock", outvalid, pol);
          end
        end

    // R8 immediate clear (with simultaneous update in the same cycle)
    wr_cfg(8'h00);
    out_stage = 4'hB; pulse(1);
    chk("R8 loaded", pins_out, 4'hB);
    out_stage = 4'h6;
    @(negedge clk); wde = 1; eof = 1;
    @(negedge clk); wde = 0; eof = 0;
    chk("R8 cleared", pins_out, 0);

    // R9 deferred clear
    wr_cfg(8'h08);
    out_stage = 4'hD; pulse(1);
    chk("R9 loaded", pins_out, 4'hD);
    pulse(5);
    chk("R9 held", pins_out, 4'hD);
    repeat (3) @(negedge clk);
    chk("R9 still held", pins_out, 4'hD);
    out_stage = 4'h7; pulse(1);
    chk("R9 cleared at event", pins_out, 0);
    chk("R9 strobe", outvalid, 1);
    pulse(1);
    chk("R9 reload", pins_out, 4'h7);

    // R10 direction sweep
    pins_in = 4'hF;
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 16; d++) begin
        wr_cfg(8'(b << 2));
        dir_cfg = W'(d);
        #1 chk("R10 oe", pins_oe, b ? 4'hF : W'(d));
        pins_in = W'(15 - d) | 4'h5;
        pulse(0);
        chk("R10 capture", in_data, b ? pins_in : (pins_in & ~W'(d)));
      end

    // R11 status output
    wr_cfg(8'h20);
    @(negedge clk); sof = 1; #1 chk("R11 sof mirror", stat, 1);
    @(negedge clk); sof = 0; #1 chk("R11 sof low", stat, 0);
    wr_cfg(8'h10);
    @(negedge clk); latch = 1; sof = 1;
    #1 chk("R11 sof ignored", stat, 0);
    @(negedge clk); sof = 0;
    @(negedge clk); chk("R11 latch level", stat, 1);
    latch = 0; repeat (3) @(negedge clk);
    chk("R11 latch low", stat, 0);

    // R1 config write effect on polarity
    wr_cfg(8'h01);
    chk("R1 write", outvalid, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule